// File: doc/BRIEF.md
# Dual-Source Core Clock Switch Controller

This block chooses which of two clock generators, A and B, drives the core clock. Software writes one control word that holds, for each generator, a multiplier code, a range code and a power-down bit, plus a source-select bit. Every write is checked against the switching rules before it takes effect. A write that breaks a rule is discarded as a whole and raises a sticky error flag.

A lock timer runs for each generator. It restarts whenever that generator's settings change, and a generator may become the core source only after its timer has expired. When a legal write flips the select bit, the core clock moves to the other source without glitches. The old source's gate closes on that source's falling edge, and only then does the new source's gate open on its own falling edge. A status output reports the source actually in use once the handover has settled. Once both generators are locked, the block can switch back and forth with no lock wait.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the control word holds A multiplier 4, A range 0, A on, B multiplier 6, B range 0, B on, select 0 (generator A), so cfg_o = 0x0304. The active source is A, the A lock flag is 1, the B lock flag is 0 and the error flag is 0.
- R2: Control word layout: bits [3:0] A multiplier, [5:4] A range, [6] A off, [10:7] B multiplier, [12:11] B range, [13] B off, [14] select (1 = B), [15] error-clear. A legal write that changes a generator's fields clears that generator's lock flag (lock_o[0] = A, lock_o[1] = B) on the write edge. The flag sets exactly LOCK_CYC clock edges after the write edge.
- R3: A write that changes any multiplier, range or off field of the currently selected generator is ignored and sets the error flag.
- R4: A write that changes the select bit while the target generator's lock flag is 0 is ignored and sets the error flag. This includes a write that reconfigures the target and selects it at the same time.
- R5: A write that selects a generator whose off bit is 1 is ignored and sets the error flag. A generator that is off keeps its lock flag at 0.
- R6: A multiplier code with bit 0 set is a half-step ratio. A switch is ignored and sets the error flag when both multiplier codes are half-step. A switch from a half-step setting to a whole-number setting is accepted.
- R7: After a legal switch write, the core clock output follows the new source no later than three bus clock cycles after the write edge. At no time are both source gates open.
- R8: active_src_o shows the new source no later than five bus cycles after a legal switch write. While the handover is in progress, a further select change is ignored and sets the error flag.
- R9: The error flag stays set across later legal writes. It clears on a legal write that has bit 15 set.
- R10: Once both generators are locked, a switch back to the previous generator is accepted on the very next write, with no lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_a_clk_i | input | 1 | Clock from generator A |
| src_b_clk_i | input | 1 | Clock from generator B |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data |
| cfg_o | output | 15 | Current control word, without the error-clear bit |
| core_clk_o | output | 1 | Glitch-free core clock |
| active_src_o | output | 1 | Source in use: 0 = A, 1 = B |
| lock_o | output | 2 | Lock flags, bit 0 = A, bit 1 = B |
| err_o | output | 1 | Sticky rule-violation flag |

## Verification
Writes are driven at the falling bus edge, so the control word and the error flag are due right after the write edge and are sampled at the next falling edge. Lock flags are sampled one edge before and exactly at edge LOCK_CYC after the write. The core clock is compared with the new source from 12 ns (three bus cycles) after the switch edge, at sample offsets that fall between every source edge. The status bit is read after the fifth bus edge, and busy-rejection writes are issued back to back with the switch.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  parameter int MULT_W = 4;
  parameter int RNG_W  = 2;

  typedef struct packed {
    logic             off;
    logic [RNG_W-1:0] rng;
    logic [MULT_W-1:0] mult;
  } gen_cfg_t;

  typedef struct packed {
    logic     sel;
    gen_cfg_t b;
    gen_cfg_t a;
  } cfg_t;

  typedef struct packed {
    logic err_clr;
    cfg_t cfg;
  } wr_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam int WR_W  = $bits(wr_t);
endpackage

// File: rtl/clk_src_regs.sv
module clk_src_regs
  import clk_src_pkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  wr_t        wr_i,
  input  logic [1:0] lock_i,
  input  logic       busy_i,
  output cfg_t       cfg_o,
  output logic [1:0] reload_o,
  output logic       err_o
);
  cfg_t cfg_q;
  logic err_q;
  logic [1:0] chg;
  logic bad_cfg, sw, tgt_off, half_pair, bad_sw, illegal, accept;

  always_comb begin
    chg[0]    = wr_i.cfg.a != cfg_q.a;
    chg[1]    = wr_i.cfg.b != cfg_q.b;
    bad_cfg   = chg[cfg_q.sel];
    sw        = wr_i.cfg.sel != cfg_q.sel;
    tgt_off   = wr_i.cfg.sel ? wr_i.cfg.b.off : wr_i.cfg.a.off;
    half_pair = wr_i.cfg.a.mult[0] & wr_i.cfg.b.mult[0];
    bad_sw    = sw & (tgt_off | chg[wr_i.cfg.sel] | !lock_i[wr_i.cfg.sel]
                      | half_pair | busy_i);
    illegal   = bad_cfg | bad_sw;
    accept    = wr_en_i & !illegal;
    reload_o  = accept ? chg : 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST_CFG;
      err_q <= 1'b0;
    end else if (wr_en_i) begin
      if (illegal) err_q <= 1'b1;
      else begin
        cfg_q <= wr_i.cfg;
        if (wr_i.err_clr) err_q <= 1'b0;
      end
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  assert_ignore_illegal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && illegal) |=> ($stable(cfg_q) && err_q));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_en_i && wr_i.err_clr)) |=> err_q);
endmodule

// File: rtl/clk_src_lock_timer.sv
module clk_src_lock_timer #(
  parameter int LOCK_CYC    = 16,
  parameter bit INIT_LOCKED = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic off_i,
  output logic lock_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= INIT_LOCKED ? '0 : CNT_LOAD;
      lock_q <= INIT_LOCKED;
    end else if (reload_i) begin
      cnt_q  <= CNT_LOAD;
      lock_q <= 1'b0;
    end else if (!off_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;

  assert_reload_unlocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !lock_o);

  assert_off_unlocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |-> !lock_o);
endmodule

// File: rtl/clk_src_handover.sv
module clk_src_handover #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_a_clk_i,
  input  logic src_b_clk_i,
  input  logic sel_i,
  output logic core_clk_o,
  output logic active_o
);
  logic [1:0] src_clk, req, gate;
  logic [SYNC_STAGES-1:0] stat_q [2];
  logic active_q;

  assign src_clk = {src_b_clk_i, src_a_clk_i};
  // each side may open only once the other side's gate is closed
  assign req[0] = !sel_i & !gate[1];
  assign req[1] =  sel_i & !gate[0];

  for (genvar g = 0; g < 2; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic gate_q;

    always_ff @(posedge src_clk[g] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], req[g]};
    end

    always_ff @(negedge src_clk[g] or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= sync_q[SYNC_STAGES-1];
    end

    assign gate[g] = gate_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[g] <= '0;
      else         stat_q[g] <= {stat_q[g][SYNC_STAGES-2:0], gate_q};
    end
  end

  assign core_clk_o = |(src_clk & gate);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else if (stat_q[1][SYNC_STAGES-1] && !stat_q[0][SYNC_STAGES-1]) active_q <= 1'b1;
    else if (stat_q[0][SYNC_STAGES-1] && !stat_q[1][SYNC_STAGES-1]) active_q <= 1'b0;
  end

  assign active_o = active_q;

  always_comb begin
    if (rst_ni) assert_gates_exclusive_R7: assert (!(gate[0] && gate[1]));
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_src_pkg::*;
#(
  parameter int LOCK_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_MAX    = 5,
  parameter logic [MULT_W-1:0] RST_MULT_A = 4'd4,
  parameter logic [MULT_W-1:0] RST_MULT_B = 4'd6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          src_a_clk_i,
  input  logic                          src_b_clk_i,
  input  logic                          wr_en_i,
  input  logic [clk_src_pkg::WR_W-1:0]  wr_data_i,
  output logic [clk_src_pkg::CFG_W-1:0] cfg_o,
  output logic                          core_clk_o,
  output logic                          active_src_o,
  output logic [1:0]                    lock_o,
  output logic                          err_o
);
  localparam cfg_t RST_CFG = '{sel: 1'b0,
                               a: '{off: 1'b0, rng: '0, mult: RST_MULT_A},
                               b: '{off: 1'b0, rng: '0, mult: RST_MULT_B}};
  localparam int BUSY_W = $clog2(BUSY_MAX + 2);

  cfg_t       cfg_q;
  logic [1:0] reload, lock_v, off_v;
  logic       active, busy;

  assign busy = active != cfg_q.sel;

  clk_src_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_i    (wr_t'(wr_data_i)),
    .lock_i  (lock_v),
    .busy_i  (busy),
    .cfg_o   (cfg_q),
    .reload_o(reload),
    .err_o   (err_o)
  );

  assign off_v = {cfg_q.b.off, cfg_q.a.off};

  for (genvar g = 0; g < 2; g++) begin : g_lock
    clk_src_lock_timer #(.LOCK_CYC(LOCK_CYC), .INIT_LOCKED(g == 0)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .reload_i(reload[g]),
      .off_i   (off_v[g]),
      .lock_o  (lock_v[g])
    );
  end

  clk_src_handover #(.SYNC_STAGES(SYNC_STAGES)) u_handover (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_a_clk_i(src_a_clk_i),
    .src_b_clk_i(src_b_clk_i),
    .sel_i      (cfg_q.sel),
    .core_clk_o (core_clk_o),
    .active_o   (active)
  );

  assign cfg_o        = cfg_q;
  assign active_src_o = active;
  assign lock_o       = lock_v;

  // handover duration checker
  logic [BUSY_W-1:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       busy_cnt <= '0;
    else if (!busy)                    busy_cnt <= '0;
    else if (busy_cnt != '1)           busy_cnt <= busy_cnt + 1'b1;
  end

  assert_handover_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= BUSY_W'(BUSY_MAX));

  assert_selected_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_q.sel ? cfg_q.b.off : cfg_q.a.off));

  assert_switch_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.sel != $past(cfg_q.sel)) |->
      (cfg_q.sel ? $past(lock_v[1]) : $past(lock_v[0])));

  assert_no_half_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.sel != $past(cfg_q.sel)) |-> !(cfg_q.a.mult[0] && cfg_q.b.mult[0]));
endmodule

// File: tb/clk_src_switch_tb_top.sv
`timescale 1ns/10ps
module clk_src_switch_tb_top;
  localparam int LOCK = 16;

  logic clk = 1'b0, rst_n = 1'b0, ca = 1'b0, cb = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [14:0] cfg;
  logic core, act, err;
  logic [1:0] lock;

  int n_chk = 0, n_fail = 0;
  // shadow of the expected control word
  logic [3:0] am = 4'd4, bm = 4'd6;
  logic [1:0] ar = 2'd0, br = 2'd0;
  logic ao = 1'b0, bo = 1'b0, sl = 1'b0;

  always #2    clk = ~clk;
  always #0.5  ca  = ~ca;
  always #0.75 cb  = ~cb;

  clk_src_switch #(.LOCK_CYC(LOCK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_a_clk_i(ca), .src_b_clk_i(cb),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .cfg_o(cfg), .core_clk_o(core),
    .active_src_o(act), .lock_o(lock), .err_o(err));

  function automatic logic [15:0] pack(logic clr);
    return {clr, sl, bo, br, bm, ao, ar, am};
  endfunction

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic wr_raw(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic clr);
    wr_raw(pack(clr));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_core(input string req, input logic want_b);
    int bad = 0;
    #0.1;
    for (int i = 0; i < 16; i++) begin
      if (core !== (want_b ? cb : ca)) bad++;
      #0.25;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    chk("R1 cfg", cfg, 32'h0304);
    chk("R1 active", act, 0);
    chk("R1 lock", lock, 2'b01);
    chk("R1 err", err, 0);
  endtask

  task automatic t_lock;
    idle(LOCK + 2);
    chk("R2 both locked", lock, 2'b11);
    bm = 4'd8; wr(0);
    chk("R2 cfg accepted", cfg, pack(0));
    chk("R2 lock cleared", lock[1], 0);
    idle(LOCK - 1);
    chk("R2 still unlocked", lock[1], 0);
    idle(1);
    chk("R2 locked on time", lock[1], 1);
  endtask

  task automatic t_sel_cfg;
    wr_raw(pack(0) ^ 16'h0001);
    chk("R3 mult ignored", cfg, pack(0));
    chk("R3 err set", err, 1);
    wr(0);
    chk("R9 err sticky", err, 1);
    wr(1);
    chk("R9 err cleared", err, 0);
    wr_raw(pack(0) | 16'h0040);
    chk("R3 off ignored", cfg, pack(0));
    chk("R3 err on off", err, 1);
    wr(1);
  endtask

  task automatic t_unlocked;
    bm = 4'd10; wr(0);
    wr_raw(pack(0) | 16'h4000);
    chk("R4 switch ignored", cfg, pack(0));
    chk("R4 err", err, 1);
    wr(1);
    idle(LOCK + 1);
    wr_raw(pack(0) ^ 16'h4080);
    chk("R4 reconfig+select ignored", cfg, pack(0));
    chk("R4 err combined", err, 1);
    wr(1);
    idle(LOCK + 1);
  endtask

  task automatic t_off;
    bo = 1'b1; wr(0);
    idle(LOCK + 2);
    chk("R5 off stays unlocked", lock[1], 0);
    wr_raw(pack(0) | 16'h4000);
    chk("R5 select off ignored", cfg, pack(0));
    chk("R5 err", err, 1);
    wr(1);
    bo = 1'b0; wr(0);
    idle(LOCK + 2);
    chk("R5 relocked", lock[1], 1);
  endtask

  task automatic t_switch;
    sl = 1'b1; wr(0);
    chk("R7 switch accepted", cfg, pack(0));
    #10;
    chk_core("R7 core from B within 3 cycles", 1'b1);
    idle(2);
    chk("R8 status B", act, 1);
  endtask

  task automatic t_half;
    am = 4'd9; wr(0);
    idle(LOCK + 2);
    sl = 1'b0; wr(0);
    chk("R6 half to whole accepted", cfg, pack(0));
    chk("R6 no err", err, 0);
    idle(6);
    chk("R6 status A", act, 0);
    bm = 4'd13; wr(0);
    idle(LOCK + 2);
    wr_raw(pack(0) | 16'h4000);
    chk("R6 half pair ignored", cfg, pack(0));
    chk("R6 err", err, 1);
    wr(1);
    bm = 4'd12; wr(0);
    idle(LOCK + 2);
    sl = 1'b1; wr(0);
    chk("R6 whole target accepted", cfg, pack(0));
    idle(6);
    chk("R6 status B", act, 1);
  endtask

  task automatic t_back;
    sl = 1'b0; wr(0);
    chk("R10 switch back without wait", err, 0);
    wr_raw(pack(0) | 16'h4000);
    chk("R8 switch while busy ignored", cfg, pack(0));
    chk("R8 err while busy", err, 1);
    wr(1);
    idle(5);
    chk("R10 status A", act, 0);
    chk_core("R10 core from A", 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_lock();
    t_sel_cfg();
    t_unlocked();
    t_off();
    t_switch();
    t_half();
    t_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule